// File: doc/BRIEF.md
# Dynamic Bus Sizing Transfer Sequencer

This block sits between a processor-side request port and a 16-bit external data bus. It takes one operand transfer at a time: a byte, word or long word, read or write, at a given address. It breaks the operand into as many external bus cycles as the addressed slave needs. The slave states its port width on every cycle through a two-bit acknowledge. The block therefore finds the port width at run time. A counter of the bytes still to move sets the size code and the split, so no fixed data bus width is built in.

On every cycle the block drives the address (bit 0 included), a size code, the direction and the write data lanes. It then waits for the acknowledge. For a regular cycle the acknowledge comes from the slave, and each clock without it is one wait state. For a fast-termination cycle the acknowledge is made inside the block. This happens when the external chip-select match `fast_sel` is high in the address clock, after a programmed number of wait states. Read bytes are gathered most significant first into a right-aligned result. Word and long-word requests at odd addresses are refused before any bus cycle starts.

The state machine has seven states. `S_IDLE` waits for a request. `S_REJECT` gives the one-clock refusal pulse. `S_ADDR` is the address clock of every bus cycle. `S_WAIT` samples the slave acknowledge once per clock. `S_TERM` is the release clock of a regular cycle. `S_FAST` counts the programmed wait states of a fast cycle. `S_DONE` gives the completion pulse.

The transitions are:
- idle-to-reject: a misaligned start.
- idle-to-address: an accepted start.
- reject-to-idle.
- address-to-wait: `fast_sel` low.
- address-to-fast: `fast_sel` high.
- wait-to-wait: no acknowledge.
- wait-to-term: acknowledge seen.
- term-to-address: bytes remain.
- term-to-done: nothing remains.
- fast-to-fast: wait count not yet zero.
- fast-to-address: count zero and bytes remain.
- fast-to-done: count zero and nothing remains.
- done-to-idle.

Top module: `bus_sizer`

## Requirements
- R1: After reset the block is idle: `bus_cyc`, `busy`, `done` and `reject` are all low.
- R2: A start in idle with `req_size` other than 01 and `req_addr[0]`=1 gives a one-clock `reject` in the next clock. No bus cycle is started.
- R3: An acknowledge of 10 marks an 8-bit port. That cycle moves exactly one byte, taken from or placed on lane [15:8], at even and at odd addresses alike.
- R4: An acknowledge with bit 0 set (01, or 11) marks a 16-bit port. When at least two bytes remain and the address is even, the cycle moves two bytes, the more significant one on lane [15:8].
- R5: When a 16-bit port moves a single byte, that byte is on lane [15:8] at an even address and on lane [7:0] at an odd address.
- R6: On a write, a cycle that could move two bytes (two or more remain, even address) drives {first, second} on the bus. Every other write cycle drives the next byte on both lanes.
- R7: The request size code is 01 for a byte, 10 for a word and any other value for a long word. `bus_siz` gives the bytes still remaining, as 01, 10, 11 or 00 (four). After each cycle the address goes up by the bytes moved, wrapping at the address width. So a long word through an 8-bit port shows sizes 00, 11, 10, 01 at four ascending addresses.
- R8: A regular cycle holds `bus_cyc` high, with a stable address and size, from the address clock through the clock in which a nonzero `bus_ack` is sampled. `bus_cyc` is then low for one clock. With no wait states this is three clocks, and each clock without an acknowledge adds one.
- R9: When `fast_sel` is high in the address clock, the cycle ends after 2+`fast_wait` clocks with `bus_cyc` high throughout. The port width comes from `fast_port8` and `bus_ack` is ignored. The next cycle, or `done`, follows with no release clock.
- R10: `done` is high for one clock after the last cycle. For a read, `rdata` then holds the operand right-aligned, with the byte from the lowest address most significant.
- R11: A `req_start` while `busy` is high is ignored. It neither disturbs the transfer in progress nor raises `reject`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start a transfer (taken only in idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 01 byte, 10 word, other long word |
| req_addr | input | AW | Byte address of the operand |
| req_wdata | input | 32 | Write operand, right-aligned |
| busy | output | 1 | A request is being handled |
| done | output | 1 | One-clock completion pulse |
| reject | output | 1 | One-clock misaligned-request pulse |
| rdata | output | 32 | Assembled read operand, right-aligned |
| bus_cyc | output | 1 | Bus cycle active |
| bus_write | output | 1 | Direction of the current cycle |
| bus_siz | output | 2 | Bytes remaining in the operand |
| bus_addr | output | AW | Address of the current cycle |
| bus_dout | output | 16 | Write data lanes |
| bus_din | input | 16 | Read data lanes |
| bus_ack | input | 2 | Slave acknowledge / port width |
| fast_sel | input | 1 | Chip-select match, sampled in the address clock |
| fast_port8 | input | 1 | Port width of a fast cycle (1 = 8-bit) |
| fast_wait | input | WSW | Wait states before the internal acknowledge |

## Verification
The bench builds the block with a 16-bit address and a 2-bit wait field. These values bring two limits within reach. First, three programmed wait states, the largest fast-termination delay, are used in a fast write to an 8-bit port. Second, a long word that starts two bytes below the top of the address space must wrap to address zero part-way through. Within those bounds the bench mixes port widths from one cycle to the next inside a single long word. It also changes between slave-acknowledged and fast cycles within one operand, and makes the slave wait several clocks.

// File: rtl/bus_sizer_pkg.sv
package bus_sizer_pkg;

    localparam int OPW  = 32;             // operand width
    localparam int BUSW = 16;             // external data bus width
    localparam int REMW = 3;              // remaining-byte counter width (0..4)

    localparam logic [1:0] SZ_BYTE   = 2'b01;
    localparam logic [1:0] SZ_WORD   = 2'b10;
    localparam logic [1:0] ACK_NARROW = 2'b10;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REJECT,
        S_ADDR,
        S_WAIT,
        S_TERM,
        S_FAST,
        S_DONE
    } seq_state_t;

endpackage

// File: rtl/bsz_step.sv
module bsz_step
    import bus_sizer_pkg::*;
(
    input  logic [REMW-1:0] remain,
    input  logic            addr_lsb,
    input  logic            narrow,
    output logic            pair_ok,
    output logic            two
);
    always_comb begin
        pair_ok = (remain >= REMW'(2)) && !addr_lsb;
        two     = pair_ok && !narrow;
    end
endmodule

// File: rtl/bsz_datapath.sv
module bsz_datapath
    import bus_sizer_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic            pair_ok,
    input  logic            two,
    input  logic            narrow,
    input  logic            addr_lsb,
    input  logic [1:0]      size_code,
    input  logic [OPW-1:0]  wdata,
    input  logic [BUSW-1:0] din,
    output logic [BUSW-1:0] dout,
    output logic [OPW-1:0]  rdata
);
    logic [OPW-1:0] wsh;
    logic [OPW-1:0] acc;
    logic [7:0]     pick;

    always_comb begin
        pick = (narrow || !addr_lsb) ? din[15:8] : din[7:0];
        dout = pair_ok ? wsh[OPW-1 -: BUSW] : {2{wsh[OPW-1 -: 8]}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wsh <= '0;
            acc <= '0;
        end else if (load) begin
            unique case (size_code)
                SZ_BYTE: wsh <= {wdata[7:0], 24'h0};
                SZ_WORD: wsh <= {wdata[15:0], 16'h0};
                default: wsh <= wdata;
            endcase
            acc <= '0;
        end else if (step) begin
            if (two) begin
                wsh <= {wsh[OPW-BUSW-1:0], {BUSW{1'b0}}};
                acc <= {acc[OPW-BUSW-1:0], din};
            end else begin
                wsh <= {wsh[OPW-9:0], 8'h0};
                acc <= {acc[OPW-9:0], pick};
            end
        end
    end

    assign rdata = acc;
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
    import bus_sizer_pkg::*;
#(
    parameter int AW  = 24,
    parameter int WSW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_start,
    input  logic            req_write,
    input  logic [1:0]      req_size,
    input  logic [AW-1:0]   req_addr,
    input  logic [31:0]     req_wdata,
    output logic            busy,
    output logic            done,
    output logic            reject,
    output logic [31:0]     rdata,
    output logic            bus_cyc,
    output logic            bus_write,
    output logic [1:0]      bus_siz,
    output logic [AW-1:0]   bus_addr,
    output logic [15:0]     bus_dout,
    input  logic [15:0]     bus_din,
    input  logic [1:0]      bus_ack,
    input  logic            fast_sel,
    input  logic            fast_port8,
    input  logic [WSW-1:0]  fast_wait
);
    seq_state_t      state, nxt;
    logic [AW-1:0]   addr;
    logic [REMW-1:0] remain, remain_nx, n_bytes;
    logic            wr, fast_narrow;
    logic [WSW-1:0]  wcnt;
    logic            misalign, ack_seen, narrow, step, load;
    logic            pair_ok, two;

    always_comb begin
        misalign  = (req_size != SZ_BYTE) && req_addr[0];
        n_bytes   = (req_size == SZ_BYTE) ? REMW'(1) :
                    (req_size == SZ_WORD) ? REMW'(2) : REMW'(4);
        ack_seen  = (bus_ack != 2'b00);
        narrow    = (state == S_FAST) ? fast_narrow : (bus_ack == ACK_NARROW);
        step      = ((state == S_WAIT) && ack_seen) ||
                    ((state == S_FAST) && (wcnt == '0));
        load      = (state == S_IDLE) && req_start && !misalign;
        remain_nx = remain - (two ? REMW'(2) : REMW'(1));
    end

    bsz_step u_step (
        .remain   (remain),
        .addr_lsb (addr[0]),
        .narrow   (narrow),
        .pair_ok  (pair_ok),
        .two      (two)
    );

    bsz_datapath u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .pair_ok   (pair_ok),
        .two       (two),
        .narrow    (narrow),
        .addr_lsb  (addr[0]),
        .size_code (req_size),
        .wdata     (req_wdata),
        .din       (bus_din),
        .dout      (bus_dout),
        .rdata     (rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (req_start) nxt = misalign ? S_REJECT : S_ADDR;
            S_REJECT: nxt = S_IDLE;
            S_ADDR:   nxt = fast_sel ? S_FAST : S_WAIT;
            S_WAIT:   if (ack_seen) nxt = S_TERM;
            S_TERM:   nxt = (remain == '0) ? S_DONE : S_ADDR;
            S_FAST:   if (wcnt == '0) nxt = (remain_nx == '0) ? S_DONE : S_ADDR;
            S_DONE:   nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // transfer bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr        <= '0;
            remain      <= '0;
            wr          <= 1'b0;
            wcnt        <= '0;
            fast_narrow <= 1'b0;
        end else begin
            if (load) begin
                addr   <= req_addr;
                remain <= n_bytes;
                wr     <= req_write;
            end
            if (state == S_ADDR) begin
                wcnt        <= fast_wait;
                fast_narrow <= fast_port8;
            end else if ((state == S_FAST) && (wcnt != '0)) begin
                wcnt <= wcnt - WSW'(1);
            end
            if (step) begin
                addr   <= addr + (two ? AW'(2) : AW'(1));
                remain <= remain_nx;
            end
        end
    end

    // outputs
    always_comb begin
        bus_cyc   = (state == S_ADDR) || (state == S_WAIT) || (state == S_FAST);
        busy      = (state != S_IDLE);
        done      = (state == S_DONE);
        reject    = (state == S_REJECT);
        bus_write = wr;
        bus_siz   = remain[1:0];
        bus_addr  = addr;
    end
endmodule

// File: rtl/bsz_checker.sv
module bsz_checker
    import bus_sizer_pkg::*;
#(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input seq_state_t    state,
    input logic          req_start,
    input logic [1:0]    req_size,
    input logic [AW-1:0] req_addr,
    input logic          busy,
    input logic          done,
    input logic          reject,
    input logic          bus_cyc,
    input logic          bus_write,
    input logic [1:0]    bus_siz,
    input logic [AW-1:0] bus_addr,
    input logic [15:0]   bus_dout,
    input logic [1:0]    bus_ack
);
    // R2
    misalign_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && req_start && req_size != 2'b01 && req_addr[0])
        |=> (reject && !bus_cyc));

    // R7
    triple_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_siz == 2'b11) |-> bus_addr[0]);

    // R6
    lane_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_write && (bus_siz == 2'b01 || bus_addr[0]))
        |-> (bus_dout[15:8] == bus_dout[7:0]));

    // R8
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT) |-> ($stable(bus_addr) && $stable(bus_siz)));

    // R8
    term_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && bus_ack != 2'b00) |=> !bus_cyc);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_start) |=> !reject);
endmodule

bind bus_sizer bsz_checker #(.AW(AW)) u_bsz_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .req_start (req_start),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .busy      (busy),
    .done      (done),
    .reject    (reject),
    .bus_cyc   (bus_cyc),
    .bus_write (bus_write),
    .bus_siz   (bus_siz),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout),
    .bus_ack   (bus_ack)
);

// File: tb/test_bus_sizer.sv
`timescale 1ns/1ps
module test_bus_sizer;
    localparam int AW  = 16;
    localparam int WSW = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n;
    logic req_start, req_write;
    logic [1:0] req_size;
    logic [AW-1:0] req_addr;
    logic [31:0] req_wdata;
    logic busy, done, reject;
    logic [31:0] rdata;
    logic bus_cyc, bus_write;
    logic [1:0] bus_siz;
    logic [AW-1:0] bus_addr;
    logic [15:0] bus_dout, bus_din;
    logic [1:0] bus_ack;
    logic fast_sel, fast_port8;
    logic [WSW-1:0] fast_wait;

    bus_sizer #(.AW(AW), .WSW(WSW)) i_bus_sizer (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .reject(reject), .rdata(rdata),
        .bus_cyc(bus_cyc), .bus_write(bus_write), .bus_siz(bus_siz),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din),
        .bus_ack(bus_ack), .fast_sel(fast_sel), .fast_port8(fast_port8),
        .fast_wait(fast_wait)
    );

    // one entry per clock: stimulus for that clock and expected outputs
    typedef struct {
        logic st; logic sw; logic [1:0] ssz; logic [AW-1:0] sa; logic [31:0] swd;
        logic [1:0] ack; logic [15:0] din; logic fsel; logic fp8; logic [WSW-1:0] fw;
        logic cyc; logic bsy; logic wr; logic [AW-1:0] addr; logic [1:0] siz;
        logic [15:0] dout; logic cdout; logic dn; logic rej; logic crd; logic [31:0] rd;
        int tag;
    } ent_t;

    ent_t q[$];
    int checks = 0;
    int fails  = 0;
    int idle_tag = 1;

    function automatic ent_t blank(int tag);
        ent_t e;
        e.st = 0; e.sw = 0; e.ssz = 0; e.sa = '0; e.swd = 0;
        e.ack = 0; e.din = 0; e.fsel = 0; e.fp8 = 0; e.fw = '0;
        e.cyc = 0; e.bsy = 0; e.wr = 0; e.addr = '0; e.siz = 0;
        e.dout = 0; e.cdout = 0; e.dn = 0; e.rej = 0; e.crd = 0; e.rd = 0;
        e.tag = tag;
        return e;
    endfunction

    function automatic logic [7:0] mem(int a);
        return 8'(((a & 16'hFFFF) * 37) + 11);
    endfunction

    // behavioural model of one request, expanded clock by clock
    task automatic push_req(bit wr, logic [1:0] sz, int addr0, logic [31:0] wd,
                            int p8m, int fm, int w, bit poke, int tag);
        ent_t e, b;
        int n, rem, k, mv, c, a;
        logic [31:0] acc;
        logic [7:0] bk [4];
        logic [15:0] dv, dn16;
        bit p8, f, pair;
        n = (sz == 2'b01) ? 1 : (sz == 2'b10) ? 2 : 4;
        for (int i = 0; i < 4; i++) bk[i] = (i < n) ? 8'(wd >> (8 * (n - 1 - i))) : 8'h0;
        e = blank(tag); e.st = 1; e.sw = wr; e.ssz = sz; e.sa = AW'(addr0); e.swd = wd;
        q.push_back(e);
        if (n > 1 && (addr0 % 2) == 1) begin
            e = blank(tag); e.rej = 1; e.bsy = 1; q.push_back(e);   // R2
            return;
        end
        rem = n; k = 0; c = 0; a = addr0; acc = 0;
        while (rem > 0) begin
            p8   = ((p8m >> c) & 1) == 1;
            f    = ((fm >> c) & 1) == 1;
            pair = (rem >= 2) && ((a % 2) == 0);
            mv   = (!p8 && pair) ? 2 : 1;
            dv   = pair ? {bk[k], bk[k+1]} : {bk[k], bk[k]};
            dn16 = p8 ? {mem(a), 8'hEE} : {mem(a & ~1), mem(a | 1)};
            b = blank(tag); b.cyc = 1; b.bsy = 1; b.wr = wr; b.addr = AW'(a);
            b.siz = 2'(rem); b.dout = dv; b.cdout = wr; b.fp8 = p8; b.fw = WSW'(w);
            e = b; e.fsel = f;
            if (poke && c == 1) begin e.st = 1; e.ssz = 2'b10; e.sa = AW'(1); end  // R11
            q.push_back(e);
            for (int i = 0; i <= w; i++) begin
                e = b;
                if (f) e.ack = 2'b10;                                  // R9 ignored
                else   e.ack = (i == w) ? (p8 ? 2'b10 : 2'b01) : 2'b00;
                if (i == w) e.din = dn16;
                q.push_back(e);
            end
            if (!f) begin e = blank(tag); e.bsy = 1; q.push_back(e); end  // R8 release
            for (int j = 0; j < mv; j++) acc = {acc[23:0], mem(a + j)};
            a = (a + mv) & 16'hFFFF; rem -= mv; k += mv; c++;
        end
        e = blank(tag); e.dn = 1; e.bsy = 1; e.crd = !wr; e.rd = acc;   // R10
        q.push_back(e);
    endtask

    task automatic tick();
        ent_t e;
        bit ok;
        @(negedge clk);
        if (q.size() > 0) begin e = q.pop_front(); idle_tag = e.tag; end
        else e = blank(idle_tag);
        ok = (bus_cyc === e.cyc) && (busy === e.bsy) && (done === e.dn) && (reject === e.rej);
        if (e.cyc) ok = ok && (bus_addr === e.addr) && (bus_siz === e.siz) && (bus_write === e.wr);
        if (e.cdout) ok = ok && (bus_dout === e.dout);
        if (e.crd) ok = ok && (rdata === e.rd);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d t=%0t actual/expected cyc %b/%b busy %b/%b addr %h/%h siz %b/%b dout %h/%h done %b/%b rej %b/%b rdata %h/%h",
                     e.tag, $time, bus_cyc, e.cyc, busy, e.bsy, bus_addr, e.addr, bus_siz, e.siz,
                     bus_dout, e.dout, done, e.dn, reject, e.rej, rdata, e.rd);
        end
        req_start = e.st; req_write = e.sw; req_size = e.ssz; req_addr = e.sa; req_wdata = e.swd;
        bus_ack = e.ack; bus_din = e.din; fast_sel = e.fsel; fast_port8 = e.fp8; fast_wait = e.fw;
    endtask

    task automatic drain();
        while (q.size() > 0) tick();
        tick();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(64'd8 * 200000);
        fails++;
        $display("FAIL R8 watchdog expired, actual still running, expected finished");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        req_start = 0; req_write = 0; req_size = 0; req_addr = '0; req_wdata = 0;
        bus_ack = 0; bus_din = 0; fast_sel = 0; fast_port8 = 0; fast_wait = '0;
        idle_tag = 1;                                   // R1 reset state
        repeat (3) tick();
        rst_n = 1'b1;
        repeat (2) tick();

        push_req(0, 2'b01, 'h100, 0, 0, 0, 0, 0, 5); drain();   // R5 even byte, 16-bit
        push_req(0, 2'b01, 'h101, 0, 0, 0, 0, 0, 5); drain();   // R5 odd byte, 16-bit
        push_req(0, 2'b01, 'h701, 0, 1, 0, 0, 0, 3); drain();   // R3 odd byte, 8-bit
        push_req(1, 2'b01, 'h203, 32'hA5, 1, 0, 0, 0, 6); drain();  // R6 duplicated byte
        push_req(1, 2'b01, 'h204, 32'h3C, 0, 0, 0, 0, 6); drain();  // R6
        push_req(0, 2'b10, 'h300, 0, 0, 0, 1, 0, 4); drain();   // R4 word, wait state
        push_req(1, 2'b10, 'h302, 32'hBEEF, 3, 0, 0, 0, 3); drain();  // R3 word to 8-bit
        push_req(0, 2'b00, 'h400, 0, 15, 0, 2, 0, 7); drain();  // R7 long via 8-bit, R8 waits
        push_req(1, 2'b00, 'h408, 32'h12345678, 0, 0, 0, 0, 4); drain();  // R4 long 16-bit
        push_req(0, 2'b00, 'h410, 0, 1, 0, 0, 0, 7); drain();   // R7 mixed widths
        push_req(0, 2'b00, 'h420, 0, 0, 3, 0, 0, 9); drain();   // R9 fast, no wait
        push_req(1, 2'b10, 'h430, 32'hCAFE, 3, 3, 3, 0, 9); drain();  // R9 fast, max wait
        push_req(1, 2'b00, 'h440, 32'h0BADF00D, 0, 2, 1, 0, 9); drain();  // R9 mixed
        push_req(0, 2'b00, 'hFFFE, 0, 0, 0, 0, 0, 7); drain();  // R7 address wrap
        push_req(0, 2'b10, 'h501, 0, 0, 0, 0, 0, 2); drain();   // R2 misaligned word
        push_req(1, 2'b00, 'h503, 32'h1, 0, 0, 0, 0, 2); drain();  // R2 misaligned long
        push_req(0, 2'b00, 'h600, 0, 15, 0, 0, 1, 11); drain(); // R11 start while busy
        push_req(0, 2'b10, 'h610, 0, 0, 0, 0, 0, 10);           // R10 back-to-back
        push_req(1, 2'b01, 'h613, 32'h77, 0, 1, 2, 0, 10); drain();
        summary();
    end
endmodule